// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three clock sources drives the system clock: the internal oscillator, the external oscillator or the PLL. Software writes a 2-bit request. The block moves a 2-bit status to that request once the requested source reports ready. The status drives a one-hot select for an external glitch-free clock mux. Because the select is decoded straight from the status, the status always names the source that is actually selected.

Hardware can override software. The request and the status both return to the internal oscillator on the clock edge after a low-power-exit event. They also return there when clock security is enabled and the external oscillator fails while it is in use. It counts as in use when it is selected directly, or when the PLL is selected and fed from it. This fallback wins over a software write in the same cycle. The internal oscillator is taken to be always running, so the fallback does not wait for its ready flag.

Codes used on all code ports: 00 internal oscillator, 01 external oscillator, 10 PLL, 11 not permitted. Ready bit k and select bit k belong to source code k.

Top module: `sysclk_switch`

## Requirements
- R1: With `rst_n` low at a clock edge, `req_code` and `stat_code` become 00 and `src_sel` becomes 3'b001.
- R2: A write (`wr_en`=1) of 00, 01 or 10 appears on `req_code` after the next clock edge, unless a forced fallback occurs in that cycle.
- R3: A write of 11 is ignored, and `req_code` keeps its previous value.
- R4: When `req_code` differs from `stat_code` and `src_rdy[req_code]` is high at a clock edge, `stat_code` takes the value of `req_code` after that edge.
- R5: While the requested source's ready bit is low, `stat_code` and `src_sel` keep showing the old source.
- R6: `src_sel` is one-hot at all times. Bit k is set exactly when `stat_code` equals k, so select and status change in the same cycle.
- R7: `lp_exit`=1 at a clock edge sets both `req_code` and `stat_code` to 00 after that edge.
- R8: With `css_en`=1, an `ext_fail`=1 at a clock edge while `stat_code` is 01 sets `req_code` and `stat_code` to 00.
- R9: With `css_en`=1 and `stat_code` at 10, `ext_fail` forces 00 only when `pll_from_ext`=1. With `pll_from_ext`=0 it has no effect.
- R10: With `css_en`=0, `ext_fail` has no effect on `req_code` or `stat_code`.
- R11: A forced fallback (R7, R8, R9) takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe for the request field |
| wr_code | input | 2 | Requested source code |
| src_rdy | input | 3 | Ready flags, bit k for source code k |
| pll_from_ext | input | 1 | PLL reference is the external oscillator |
| css_en | input | 1 | Clock security enable |
| ext_fail | input | 1 | External oscillator failure detected |
| lp_exit | input | 1 | Pulse on leaving a low-power mode |
| req_code | output | 2 | Readable request field |
| stat_code | output | 2 | Source in use, written only by hardware |
| src_sel | output | 3 | One-hot select for the clock mux |

## Verification
The main sweep starts from each of the three sources. From each one it writes all four codes, each under all eight ready patterns. This separates a switch that waits for the right ready bit from one that waits for the wrong bit or for none, and it confirms that code 11 leaves everything unchanged. Directed cases then raise the failure flag under every combination of security enable, selected source and PLL reference. This tells real use of the external oscillator apart from the cases that must be ignored. Low-power exit and failure are also applied together with a competing software write, to show which one wins.

// File: rtl/sysclk_pkg.sv
// Package: shared source codes and sizes for the system clock switch.
// Assumes codes are dense from zero, with the top code reserved as illegal.
package sysclk_pkg;

    localparam int unsigned SRC_N = 3;
    localparam int unsigned SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PLL = 2'b10,
        SRC_BAD = 2'b11
    } src_e;

endpackage

// File: rtl/sysclk_fallback.sv
// Fallback detector: raises force_int when hardware must return to the
// internal oscillator, either on low-power exit or on an external oscillator
// failure while that oscillator feeds the system clock.
// Assumes stat is the source actually driving the clock.
module sysclk_fallback
    import sysclk_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic [W-1:0] stat,
    input  logic         pll_from_ext,
    input  logic         css_en,
    input  logic         ext_fail,
    input  logic         lp_exit,
    output logic         force_int
);

    logic ext_in_use;

    // Decide whether the external oscillator drives the clock, directly or via the PLL.
    always_comb begin
        ext_in_use = (stat == W'(SRC_EXT)) || ((stat == W'(SRC_PLL)) && pll_from_ext);
    end

    // Combine the two override causes.
    always_comb begin
        force_int = lp_exit || (css_en && ext_fail && ext_in_use);
    end

endmodule

// File: rtl/sysclk_req_reg.sv
// Request register: holds the software-written source request.
// A forced fallback clears it and wins over a same-cycle write.
// Writes of the reserved code are dropped.
module sysclk_req_reg
    import sysclk_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         force_int,
    input  logic         wr_en,
    input  logic [W-1:0] wr_code,
    output logic [W-1:0] req_q
);

    logic wr_ok;

    // Accept only writes of a permitted code.
    always_comb begin
        wr_ok = wr_en && (wr_code != W'(SRC_BAD));
    end

    // Update the request: reset, then fallback, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= W'(SRC_INT);
        end else if (force_int) begin
            req_q <= W'(SRC_INT);
        end else if (wr_ok) begin
            req_q <= wr_code;
        end
    end

endmodule

// File: rtl/sysclk_stat_fsm.sv
// Status tracker: moves the in-use source to the request once the
// requested source is ready. A fallback returns it to the internal
// oscillator at once, since that oscillator is assumed always running.
module sysclk_stat_fsm
    import sysclk_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         force_int,
    input  logic [W-1:0] req,
    input  logic [N-1:0] src_rdy,
    output logic [W-1:0] stat_q
);

    localparam int unsigned CODES = 1 << W;

    logic [CODES-1:0] rdy_pad;
    logic             go;

    // Pad the ready flags so every code indexes a defined bit.
    always_comb begin
        rdy_pad = CODES'(src_rdy);
    end

    // A switch is due when the request differs from the status and its source is ready.
    always_comb begin
        go = (req != stat_q) && rdy_pad[req];
    end

    // Advance the status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= W'(SRC_INT);
        end else if (force_int) begin
            stat_q <= W'(SRC_INT);
        end else if (go) begin
            stat_q <= req;
        end
    end

endmodule

// File: rtl/sysclk_sel_dec.sv
// Select decoder: turns the status code into a one-hot mux select.
// Assumes the status never holds the reserved code.
module sysclk_sel_dec
    import sysclk_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    parameter int unsigned W = SRC_W
) (
    input  logic [W-1:0] stat,
    output logic [N-1:0] sel
);

    // One compare per source.
    for (genvar k = 0; k < N; k++) begin : g_dec
        assign sel[k] = (stat == W'(k));
    end

endmodule

// File: rtl/sysclk_switch.sv
// Top: system clock source switch controller. Joins the request register,
// fallback detector, status tracker and select decoder.
// Assumes all inputs are synchronous to clk.
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_code,
    input  logic [N-1:0] src_rdy,
    input  logic         pll_from_ext,
    input  logic         css_en,
    input  logic         ext_fail,
    input  logic         lp_exit,
    output logic [W-1:0] req_code,
    output logic [W-1:0] stat_code,
    output logic [N-1:0] src_sel
);

    logic force_int;

    sysclk_fallback #(.W(W)) u_fb (
        .stat         (stat_code),
        .pll_from_ext (pll_from_ext),
        .css_en       (css_en),
        .ext_fail     (ext_fail),
        .lp_exit      (lp_exit),
        .force_int    (force_int)
    );

    sysclk_req_reg #(.W(W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_int (force_int),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .req_q     (req_code)
    );

    sysclk_stat_fsm #(.N(N), .W(W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_int (force_int),
        .req       (req_code),
        .src_rdy   (src_rdy),
        .stat_q    (stat_code)
    );

    sysclk_sel_dec #(.N(N), .W(W)) u_dec (
        .stat (stat_code),
        .sel  (src_sel)
    );

endmodule

// File: rtl/sysclk_switch_chk.sv
// Checker: port-level properties of the clock switch, bound to the top.
module sysclk_switch_chk
    import sysclk_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    parameter int unsigned W = SRC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_code,
    input logic [N-1:0] src_rdy,
    input logic         pll_from_ext,
    input logic         css_en,
    input logic         ext_fail,
    input logic         lp_exit,
    input logic [W-1:0] req_code,
    input logic [W-1:0] stat_code,
    input logic [N-1:0] src_sel
);

    localparam int unsigned CODES = 1 << W;

    logic [CODES-1:0] rdy_pad;
    logic             css_hit;
    logic             forced;
    logic             want_rdy;

    // Observed conditions rebuilt from ports.
    always_comb begin
        rdy_pad  = CODES'(src_rdy);
        want_rdy = rdy_pad[req_code];
        css_hit  = css_en && ext_fail &&
                   ((stat_code == W'(SRC_EXT)) || ((stat_code == W'(SRC_PLL)) && pll_from_ext));
        forced   = lp_exit || css_hit;
    end

    // R2
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code != W'(SRC_BAD) && !forced) |=> (req_code == $past(wr_code)));

    // R3
    a_r3_bad_code_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == W'(SRC_BAD) && !forced) |=> $stable(req_code));

    // R4
    a_r4_switch_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_code != stat_code && want_rdy && !forced) |=> (stat_code == $past(req_code)));

    // R5
    a_r5_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_rdy && !forced) |=> ($stable(stat_code) && $stable(src_sel)));

    // R6
    a_r6_sel_matches_stat: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(src_sel) == 1) && (stat_code < W'(N)) && src_sel[stat_code]);

    // R7
    a_r7_lp_exit: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit |=> (req_code == W'(SRC_INT) && stat_code == W'(SRC_INT)));

    // R8, R9, R11
    a_r8_css_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        css_hit |=> (req_code == W'(SRC_INT) && stat_code == W'(SRC_INT)));

    // R10
    a_r10_css_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!css_en && !lp_exit && !wr_en && (req_code == stat_code)) |=> $stable(stat_code));

endmodule

bind sysclk_switch sysclk_switch_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/test_sysclk_switch.sv
`timescale 1ns/1ps
module test_sysclk_switch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_code = 2'd0;
    logic [2:0] src_rdy = 3'b000;
    logic       pll_from_ext = 1'b0;
    logic       css_en = 1'b0;
    logic       ext_fail = 1'b0;
    logic       lp_exit = 1'b0;
    logic [1:0] req_code;
    logic [1:0] stat_code;
    logic [2:0] src_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] m_req = 2'd0;
    logic [1:0] m_stat = 2'd0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysclk_switch i_sysclk_switch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .src_rdy(src_rdy), .pll_from_ext(pll_from_ext), .css_en(css_en),
        .ext_fail(ext_fail), .lp_exit(lp_exit), .req_code(req_code),
        .stat_code(stat_code), .src_sel(src_sel)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "req_code", int'(req_code), int'(m_req));
        chk(tag, "stat_code", int'(stat_code), int'(m_stat));
        chk("R6", "src_sel", int'(src_sel), 1 << m_stat);
    endtask

    // One cycle: drive at negedge, update the model, sample just after the edge.
    task automatic step(input string tag, input bit we, input logic [1:0] d,
                        input logic [2:0] rdy, input bit px, input bit css,
                        input bit fail, input bit lp);
        bit frc;
        logic [1:0] nr, ns;
        @(negedge clk);
        wr_en = we; wr_code = d; src_rdy = rdy; pll_from_ext = px;
        css_en = css; ext_fail = fail; lp_exit = lp;
        frc = lp || (css && fail && (m_stat == 2'd1 || (m_stat == 2'd2 && px)));
        if (frc) begin
            nr = 2'd0; ns = 2'd0;
        end else begin
            nr = (we && d != 2'd3) ? d : m_req;
            ns = (m_req != m_stat && rdy[m_req]) ? m_req : m_stat;
        end
        @(posedge clk);
        #1;
        m_req = nr; m_stat = ns;
        check_all(tag);
        wr_en = 1'b0; lp_exit = 1'b0; ext_fail = 1'b0;
    endtask

    // Bring the design to a given source with all sources ready.
    task automatic go_to(input logic [1:0] s, input bit px);
        step("R7", 1'b0, 2'd0, 3'b111, px, 1'b0, 1'b0, 1'b1);
        step("R2", 1'b1, s, 3'b111, px, 1'b0, 1'b0, 1'b0);
        step("R4", 1'b0, 2'd0, 3'b111, px, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: every start source, every written code, every ready pattern.
        for (int f = 0; f < 3; f++) begin
            for (int t = 0; t < 4; t++) begin
                for (int r = 0; r < 8; r++) begin
                    go_to(2'(f), 1'b0);
                    step(t == 3 ? "R3" : "R2", 1'b1, 2'(t), 3'(r), 1'b0, 1'b0, 1'b0, 1'b0);
                    step("R5", 1'b0, 2'd0, 3'(r), 1'b0, 1'b0, 1'b0, 1'b0);
                    step("R4", 1'b0, 2'd0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
                end
            end
        end

        // Failure flag under each security setting, source and PLL reference.
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 3; s++) begin
                for (int p = 0; p < 2; p++) begin
                    go_to(2'(s), p[0]);
                    step(c == 0 ? "R10" : (s == 2 ? "R9" : "R8"),
                         1'b0, 2'd0, 3'b111, p[0], c[0], 1'b1, 1'b0);
                end
            end
        end

        // Fallback versus a same-cycle write.
        go_to(2'd1, 1'b0);
        step("R11", 1'b1, 2'd2, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0);
        go_to(2'd2, 1'b1);
        step("R11", 1'b1, 2'd1, 3'b111, 1'b1, 1'b0, 1'b0, 1'b1);
        go_to(2'd2, 1'b0);
        step("R7", 1'b1, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);

        // Reset in mid-operation.
        go_to(2'd2, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_req = 2'd0; m_stat = 2'd0;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule